// File: doc/BRIEF.md
# Loopback Code and PRBS Status Monitor

This block watches a received T1 bit stream, one bit per cycle in which the bit strobe is high, and reports whether a known test pattern is present. A mode input picks between two functions. In loop-code mode it looks for two repeating codes: the activate code `00001` (period 5) and the deactivate code `001` (period 3). Each code is judged over a fixed window of `WINDOW_BITS` received bits, 51,200 by default, which is about 33.16 ms at 1.544 Mbit/s. A code counts as present when fewer than `ERR_LIMIT` bits (512 by default, just under 1 in 100) in that window disagree with the best-aligned copy of the code.

In PRBS mode the block runs a self-seeding 2^15-1 pattern synchroniser. It reports lock on the activate flag and holds the deactivate flag low.

In both modes a sticky status-change bit records every entry into or exit from detection. It stays set until a clear strobe. The two flags always show the live state. Acting on a detected loop request is left to surrounding logic.

Top module: `lcode_mon`

## Requirements
- R1: While `rst` is high, and at the first clock edge after it is raised, `act_det`, `deact_det` and `stat_chg` are 0.
- R2: In loop-code mode (`mode_prbs`=0), `act_det` becomes 1 at the end of a window in which the stream repeats `00001`, sent left bit first, at any alignment, with fewer than `ERR_LIMIT` mismatching bits.
- R3: In loop-code mode, `deact_det` becomes 1 at the end of a window in which the stream repeats `001`, sent left bit first, at any alignment, with fewer than `ERR_LIMIT` mismatching bits.
- R4: Detection flags change only at a window boundary. A window with `ERR_LIMIT` or more mismatches against every alignment clears the flag, which is leaving detection.
- R5: `stat_chg` becomes 1 at the clock edge where either reported flag changes value, on entry or on exit. It then stays 1 until cleared.
- R6: A one-cycle `irq_clr` returns `stat_chg` to 0. If a new change falls in the same cycle as the clear, the set wins.
- R7: In PRBS mode (`mode_prbs`=1), the synchroniser predicts each bit as the XOR of the bits 15 and 14 places earlier. It loads received bits while unlocked and declares lock after `LOCK_RUN` (32) correct predictions in a row. `act_det` shows the lock state and `deact_det` is 0.
- R8: While locked, the synchroniser feeds back its own predictions. It loses lock at the end of a window in which `ERR_LIMIT` or more received bits disagreed with the prediction.
- R9: A change of `mode_prbs` restarts the window and clears all detection state. It does not set `stat_chg`.
- R10: Only cycles with `rx_bit_en`=1 advance the window or the matchers. Idle cycles between bits change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_prbs | input | 1 | 0 = loop-code detection, 1 = PRBS lock monitoring |
| rx_bit_en | input | 1 | Received bit valid this cycle |
| rx_bit | input | 1 | Received line bit |
| irq_clr | input | 1 | Clears the status-change bit |
| act_det | output | 1 | Activate code detected, or PRBS locked in PRBS mode |
| deact_det | output | 1 | Deactivate code detected (0 in PRBS mode) |
| stat_chg | output | 1 | Sticky detection-state change indication |

## Verification
A detection change and a software clear of the status bit can land in the same cycle. The bench provokes this by raising `irq_clr` together with the last bit of a window whose result flips `act_det`, and it expects `stat_chg` to read 1 afterwards. A mode switch can also coincide with a visible flag change; the bench switches mode while a flag is set and checks that the flags drop without any status change. Window lengths and error limits are shrunk by parameters so that boundary counts of one and two errors are reached quickly.

// File: rtl/lcode_pkg.sv
package lcode_pkg;
   localparam int unsigned DEF_WINDOW_BITS = 51200;
   localparam int unsigned DEF_ERR_LIMIT   = 512;
   localparam int unsigned DEF_LOCK_RUN    = 32;

   typedef enum logic {
      MODE_LOOP = 1'b0,
      MODE_PRBS = 1'b1
   } mon_mode_e;

   typedef struct packed {
      logic act;
      logic deact;
   } det_pair_t;
endpackage

// File: rtl/lcode_match.sv
// Error-tolerant detector for one repeating code: one error counter per
// possible alignment, judged at the window boundary.
module lcode_match #(
   parameter int unsigned         CODE_LEN  = 5,
   parameter logic [CODE_LEN-1:0] CODE      = 5'b00001,
   parameter int unsigned         ERR_LIMIT = 512
) (
   input  logic clk,
   input  logic clr_state,
   input  logic bit_en,
   input  logic rx_bit,
   input  logic win_last,
   output logic hit
);
   localparam int unsigned ERR_W = $clog2(ERR_LIMIT + 1);

   logic [CODE_LEN-1:0] hit_vec;

   for (genvar p = 0; p < CODE_LEN; p++) begin : g_phase
      localparam logic [CODE_LEN-1:0] ROT0 =
         CODE_LEN'((CODE << p) | (CODE >> (CODE_LEN - p)));

      logic [CODE_LEN-1:0] pat_q;
      logic [ERR_W-1:0]    err_q;
      logic [ERR_W-1:0]    err_nxt;
      logic                mis;

      assign mis     = rx_bit ^ pat_q[CODE_LEN-1];
      assign err_nxt = (err_q == ERR_W'(ERR_LIMIT)) ? err_q : err_q + ERR_W'(mis);
      assign hit_vec[p] = (err_nxt < ERR_W'(ERR_LIMIT));

      always_ff @(posedge clk) begin
         if (clr_state) begin
            pat_q <= ROT0;
            err_q <= '0;
         end else if (bit_en) begin
            pat_q <= {pat_q[CODE_LEN-2:0], pat_q[CODE_LEN-1]};
            err_q <= win_last ? '0 : err_nxt;
         end
      end
   end

   assign hit = |hit_vec;
endmodule

// File: rtl/lcode_prbs.sv
// Self-seeding pattern synchroniser with run-length lock and windowed loss.
module lcode_prbs #(
   parameter int unsigned PRBS_LEN  = 15,
   parameter int unsigned TAP_HI    = 15,
   parameter int unsigned TAP_LO    = 14,
   parameter int unsigned LOCK_RUN  = 32,
   parameter int unsigned ERR_LIMIT = 512,
   parameter bit          FLYWHEEL  = 1'b1
) (
   input  logic clk,
   input  logic clr_state,
   input  logic bit_en,
   input  logic rx_bit,
   input  logic win_last,
   output logic lock_q,
   output logic lock_nxt
);
   localparam int unsigned ERR_W = $clog2(ERR_LIMIT + 1);
   localparam int unsigned RUN_W = $clog2(LOCK_RUN + 1);

   logic [PRBS_LEN-1:0] sh_q;
   logic [RUN_W-1:0]    run_q;
   logic [ERR_W-1:0]    err_q;
   logic [ERR_W-1:0]    err_nxt;
   logic                pred;
   logic                mis;
   logic                fb_bit;

   assign pred = sh_q[TAP_HI-1] ^ sh_q[TAP_LO-1];
   assign mis  = rx_bit ^ pred;

   if (FLYWHEEL) begin : g_fly
      assign fb_bit = lock_q ? pred : rx_bit;
   end else begin : g_open
      assign fb_bit = rx_bit;
   end

   assign err_nxt = (!lock_q || err_q == ERR_W'(ERR_LIMIT)) ? err_q : err_q + ERR_W'(mis);

   always_comb begin
      lock_nxt = lock_q;
      if (bit_en) begin
         if (lock_q) begin
            if (win_last && err_nxt >= ERR_W'(ERR_LIMIT)) lock_nxt = 1'b0;
         end else if (!mis && run_q == RUN_W'(LOCK_RUN - 1)) begin
            lock_nxt = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (clr_state) begin
         sh_q   <= '0;
         run_q  <= '0;
         err_q  <= '0;
         lock_q <= 1'b0;
      end else if (bit_en) begin
         sh_q   <= {sh_q[PRBS_LEN-2:0], fb_bit};
         run_q  <= (mis || lock_q || lock_nxt) ? '0 : run_q + 1'b1;
         err_q  <= win_last ? '0 : err_nxt;
         lock_q <= lock_nxt;
      end
   end
endmodule

// File: rtl/lcode_mon.sv
module lcode_mon
   import lcode_pkg::*;
#(
   parameter int unsigned WINDOW_BITS = DEF_WINDOW_BITS,
   parameter int unsigned ERR_LIMIT   = DEF_ERR_LIMIT,
   parameter int unsigned LOCK_RUN    = DEF_LOCK_RUN,
   parameter int unsigned ACT_LEN     = 5,
   parameter logic [ACT_LEN-1:0]   ACT_CODE   = 5'b00001,
   parameter int unsigned DEACT_LEN   = 3,
   parameter logic [DEACT_LEN-1:0] DEACT_CODE = 3'b001,
   parameter int unsigned PRBS_LEN    = 15,
   parameter int unsigned PRBS_TAP_HI = 15,
   parameter int unsigned PRBS_TAP_LO = 14,
   parameter bit          FLYWHEEL    = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic mode_prbs,
   input  logic rx_bit_en,
   input  logic rx_bit,
   input  logic irq_clr,
   output logic act_det,
   output logic deact_det,
   output logic stat_chg
);
   localparam int unsigned WIN_W = $clog2(WINDOW_BITS);

   if (WINDOW_BITS < 2) begin : g_bad_win
      $error("WINDOW_BITS must be at least 2");
   end
   if (ERR_LIMIT == 0 || ERR_LIMIT > WINDOW_BITS) begin : g_bad_lim
      $error("ERR_LIMIT must lie in 1..WINDOW_BITS");
   end
   if (ACT_LEN < 2 || DEACT_LEN < 2) begin : g_bad_code
      $error("code lengths must be at least 2");
   end
   if (PRBS_TAP_HI > PRBS_LEN || PRBS_TAP_LO >= PRBS_TAP_HI || PRBS_TAP_LO == 0) begin : g_bad_tap
      $error("PRBS taps out of range");
   end
   if (LOCK_RUN < 1) begin : g_bad_run
      $error("LOCK_RUN must be at least 1");
   end

   logic [WIN_W-1:0] wcnt_q;
   logic             win_last;
   logic             mode_q;
   logic             restart;
   logic             eng_clr;
   logic             act_hit, deact_hit;
   logic             act_q, deact_q;
   logic             lock_q, lock_nxt;
   logic             judge;
   det_pair_t        rep_cur, rep_nxt;

   assign win_last = (wcnt_q == WIN_W'(WINDOW_BITS - 1));
   assign restart  = (mode_prbs != mode_q);
   assign eng_clr  = rst | restart;
   assign judge    = rx_bit_en & win_last;

   always_ff @(posedge clk) begin
      if (rst) mode_q <= MODE_LOOP;
      else     mode_q <= mode_prbs;
   end

   always_ff @(posedge clk) begin
      if (eng_clr)        wcnt_q <= '0;
      else if (rx_bit_en) wcnt_q <= win_last ? '0 : wcnt_q + 1'b1;
   end

   lcode_match #(.CODE_LEN(ACT_LEN), .CODE(ACT_CODE), .ERR_LIMIT(ERR_LIMIT)) u_act (
      .clk(clk), .clr_state(eng_clr), .bit_en(rx_bit_en), .rx_bit(rx_bit),
      .win_last(win_last), .hit(act_hit));

   lcode_match #(.CODE_LEN(DEACT_LEN), .CODE(DEACT_CODE), .ERR_LIMIT(ERR_LIMIT)) u_deact (
      .clk(clk), .clr_state(eng_clr), .bit_en(rx_bit_en), .rx_bit(rx_bit),
      .win_last(win_last), .hit(deact_hit));

   lcode_prbs #(.PRBS_LEN(PRBS_LEN), .TAP_HI(PRBS_TAP_HI), .TAP_LO(PRBS_TAP_LO),
                .LOCK_RUN(LOCK_RUN), .ERR_LIMIT(ERR_LIMIT), .FLYWHEEL(FLYWHEEL)) u_prbs (
      .clk(clk), .clr_state(eng_clr), .bit_en(rx_bit_en), .rx_bit(rx_bit),
      .win_last(win_last), .lock_q(lock_q), .lock_nxt(lock_nxt));

   always_ff @(posedge clk) begin
      if (eng_clr) begin
         act_q   <= 1'b0;
         deact_q <= 1'b0;
      end else if (judge) begin
         act_q   <= act_hit;
         deact_q <= deact_hit;
      end
   end

   always_comb begin
      if (mode_prbs == MODE_PRBS) begin
         rep_cur = '{act: lock_q,   deact: 1'b0};
         rep_nxt = '{act: lock_nxt, deact: 1'b0};
      end else begin
         rep_cur = '{act: act_q, deact: deact_q};
         rep_nxt = judge ? '{act: act_hit, deact: deact_hit} : rep_cur;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) stat_chg <= 1'b0;
      else     stat_chg <= (!restart && rep_nxt != rep_cur) | (stat_chg & ~irq_clr);
   end

   assign act_det   = rep_cur.act;
   assign deact_det = rep_cur.deact;
endmodule

// File: rtl/lcode_mon_chk.sv
module lcode_mon_chk (
   input logic clk,
   input logic rst,
   input logic mode_prbs,
   input logic rx_bit_en,
   input logic irq_clr,
   input logic act_det,
   input logic deact_det,
   input logic stat_chg,
   input logic win_last,
   input logic eng_clr,
   input logic act_q,
   input logic deact_q,
   input logic lock_q
);
   assert_reset_R1: assert property (@(posedge clk)
      rst |=> (!stat_chg && !act_q && !deact_q && !lock_q));

   assert_window_R4: assert property (@(posedge clk) disable iff (rst)
      !$stable({act_q, deact_q}) |-> $past((rx_bit_en && win_last) || eng_clr));

   assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
      (stat_chg && !irq_clr) |=> stat_chg);

   assert_rise_cause_R5: assert property (@(posedge clk) disable iff (rst)
      ($rose(stat_chg) && $stable(mode_prbs)) |-> !$stable({act_det, deact_det}));

   assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
      irq_clr |=> (!stat_chg || !$stable({act_det, deact_det}) || !$stable(mode_prbs)));

   assert_lock_bit_R7: assert property (@(posedge clk) disable iff (rst)
      !$stable(lock_q) |-> $past(rx_bit_en || eng_clr));

   assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
      eng_clr |=> (!act_q && !deact_q && !lock_q));
endmodule

bind lcode_mon lcode_mon_chk u_chk (
   .clk(clk), .rst(rst), .mode_prbs(mode_prbs), .rx_bit_en(rx_bit_en),
   .irq_clr(irq_clr), .act_det(act_det), .deact_det(deact_det),
   .stat_chg(stat_chg), .win_last(win_last), .eng_clr(eng_clr),
   .act_q(act_q), .deact_q(deact_q), .lock_q(lock_q));

// File: tb/lcode_mon_bench.sv
module lcode_mon_bench;
   localparam int WIN = 200;
   localparam int LIM = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic mode_prbs = 1'b0;
   logic rx_bit_en = 1'b0;
   logic rx_bit = 1'b0;
   logic irq_clr = 1'b0;
   logic act_det, deact_det, stat_chg;

   int n_cmp = 0;
   int n_bad = 0;
   int gidx  = 0;
   logic [14:0] ps = 15'h7fff;

   always #10 clk = ~clk;

   lcode_mon #(.WINDOW_BITS(WIN), .ERR_LIMIT(LIM)) u_lcode_mon (
      .clk(clk), .rst(rst), .mode_prbs(mode_prbs), .rx_bit_en(rx_bit_en),
      .rx_bit(rx_bit), .irq_clr(irq_clr), .act_det(act_det),
      .deact_det(deact_det), .stat_chg(stat_chg));

   // pattern codes: 0 activate, 1 deactivate, 2 all ones, 3 PRBS
   // fields: [8] mode, [7:6] pattern, [5:4] errors, [3] clear on last bit,
   //         [2] expected act, [1] expected deact, [0] expected change
   localparam int NVEC = 14;
   localparam logic [8:0] VEC [NVEC] = '{
      9'b0_00_00_0_101, 9'b0_00_01_0_100, 9'b0_00_10_0_001, 9'b0_00_00_0_101,
      9'b0_01_00_0_011, 9'b0_01_01_0_010, 9'b0_10_00_0_001, 9'b0_10_00_0_000,
      9'b0_00_00_1_101, 9'b1_11_00_0_101, 9'b1_11_01_0_100, 9'b1_11_10_0_001,
      9'b1_11_00_0_101, 9'b0_01_00_0_011 };

   task automatic check(input string req, input string what, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   function automatic logic next_bit(input logic [1:0] pat);
      logic b;
      case (pat)
         2'd0: b = (gidx % 5 == 4);
         2'd1: b = (gidx % 3 == 2);
         2'd2: b = 1'b1;
         default: begin
            b  = ps[14] ^ ps[13];
            ps = {ps[13:0], b};
         end
      endcase
      gidx++;
      return b;
   endfunction

   function automatic string req_of(input logic [1:0] pat, input logic [1:0] nerr);
      if (pat == 2'd3) return (nerr == 2'd2) ? "R8" : "R7";
      if (nerr == 2'd2 || pat == 2'd2) return "R4 R10";
      return (pat == 2'd0) ? "R2 R10" : "R3 R10";
   endfunction

   initial begin
      int cyc = 0;
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog R1: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
         end
      end
   end

   initial begin
      logic cur_mode;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", "act after reset", act_det, 1'b0);
      check("R1", "deact after reset", deact_det, 1'b0);
      check("R1", "change after reset", stat_chg, 1'b0);
      rst = 1'b0;
      cur_mode = 1'b0;

      for (int v = 0; v < NVEC; v++) begin
         logic [8:0] e;
         string rq;
         e  = VEC[v];
         rq = req_of(e[7:6], e[5:4]);
         if (e[8] != cur_mode) begin
            mode_prbs = e[8];
            cur_mode  = e[8];
            @(negedge clk);
            check("R9", "act after mode switch", act_det, 1'b0);
            check("R9", "deact after mode switch", deact_det, 1'b0);
            check("R9", "no change on mode switch", stat_chg, 1'b0);
         end
         for (int i = 0; i < WIN; i++) begin
            logic b;
            b = next_bit(e[7:6]);
            if ((e[5:4] != 2'd0 && i == 50) || (e[5:4] == 2'd2 && i == 150)) b = ~b;
            rx_bit    = b;
            rx_bit_en = 1'b1;
            irq_clr   = e[3] && (i == WIN - 1);
            @(negedge clk);
         end
         rx_bit_en = 1'b0;
         irq_clr   = 1'b0;
         check(rq, $sformatf("act v%0d", v), act_det, e[2]);
         check(rq, $sformatf("deact v%0d", v), deact_det, e[1]);
         check(e[3] ? "R6" : "R5", $sformatf("change v%0d", v), stat_chg, e[0]);
         irq_clr = 1'b1;
         @(negedge clk);
         irq_clr = 1'b0;
         check("R6", $sformatf("cleared v%0d", v), stat_chg, 1'b0);
         check("R10", $sformatf("idle keeps deact v%0d", v), deact_det, e[1]);
      end

      rst = 1'b1;
      @(negedge clk);
      check("R1", "deact after late reset", deact_det, 1'b0);
      check("R1", "act after late reset", act_det, 1'b0);
      rst = 1'b0;
      @(negedge clk);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule